// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a CPU word access into the strobe sequence a 16-bit-wide DRAM array expects. It captures a request (word address bits A20..A1, the two byte-lane strobes, the transfer direction and a bank select), then steps through a fixed sequence. The row half of the address goes on the multiplexed bus and the row strobe falls. The bus then switches to the column half and the column strobes of the requested byte lanes fall. Finally every strobe rises for a precharge gap. The length of each phase is a parameter in clock cycles.

One live input picks the bus flavour. Legacy mode drives a 9-bit multiplexed address and splits the array into two banks with one row strobe each. Wide mode adds a tenth address line and uses a single row strobe. The lower nine lines carry the same address bits in both modes, so 9-bit and 10-bit devices can share the bus. A refresh request runs a refresh cycle that uses the row strobe only. Every row strobe falls, no column strobe falls, and the row comes from an internal counter that advances after each refresh. A refresh that is pending always wins over a waiting access, but it never cuts into an access already under way.

Top module: `dram_addr_mux`

## Requirements
- R1: During the row phase, `dram_addr[8:0]` carries A17..A9 (A9 on bit 0) and `dram_addr[9]` carries A19.
- R2: During the column phase, `dram_addr[7:0]` carries A8..A1 (A1 on bit 0), `dram_addr[8]` carries A18 and `dram_addr[9]` carries A20. There is no A0 input.
- R3: `cas_hi_n` falls only when `hi_byte_n` was low at request time, and `cas_lo_n` falls only when `lo_byte_n` was low. With both byte strobes high, no column strobe falls.
- R4: With `mode_10b`=0, `dram_addr[9]` is always 0. `bank_hi`=0 selects `ras_a_n` and `bank_hi`=1 selects `ras_b_n`. `dram_addr[8:0]` matches what wide mode drives for the same address.
- R5: With `mode_10b`=1, accesses use `ras_a_n` only, `ras_b_n` stays high and `bank_hi` has no effect.
- R6: A refresh drives `ras_a_n` and `ras_b_n` low together for T_RAS cycles. No column strobe falls and `we_n` stays high. The bus carries the counter's row, with bit 9 forced to 0 in legacy mode.
- R7: The refresh row counter is 10 bits wide and starts at 0 after reset. It advances by one after each refresh and wraps from 1023 to 0.
- R8: An access shows the row for T_ROW cycles with strobes high, then keeps the row strobe low for T_RAS+T_COL+T_CAS cycles. The row is held for the first T_RAS cycles, then the column is held. Column strobes are low only in the last T_CAS of those cycles. A precharge of T_PRE cycles follows with every strobe high.
- R9: A refresh request that arrives during an access is served once that access ends and before any access requested later. When a refresh and an access are both waiting, the refresh runs first.
- R10: After reset, and whenever no request is waiting or running, every strobe and `we_n` is high and `dram_addr` is 0.
- R11: A write (`rd_wr_n`=0) holds `we_n` low through the column and column-strobe phases (T_COL+T_CAS cycles). A read never drives `we_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle pulse requesting an access with the inputs below |
| cpu_addr | input | 20 | Word address bits A20..A1 |
| hi_byte_n | input | 1 | Upper byte lane wanted, active low |
| lo_byte_n | input | 1 | Lower byte lane wanted, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| bank_hi | input | 1 | Legacy-mode bank select |
| mode_10b | input | 1 | 1 = 10-bit bus with one row strobe, 0 = 9-bit bus with two |
| refresh_req | input | 1 | One-cycle pulse requesting a refresh |
| dram_addr | output | 10 | Multiplexed DRAM address |
| ras_a_n | output | 1 | Row strobe, bank 0 or the whole array |
| ras_b_n | output | 1 | Row strobe, legacy bank 1 |
| cas_hi_n | output | 1 | Upper byte column strobe |
| cas_lo_n | output | 1 | Lower byte column strobe |
| we_n | output | 1 | Write enable, active low |

## Verification
The embedded assertions check on every cycle the rules that hold regardless of address. A column strobe never falls without a row strobe, and neither does one during a refresh. The row stays steady while the row strobe is low ahead of the column. Wide mode never touches the second row strobe. A waiting refresh always goes next, and the counter advances exactly at the end of each refresh. The bench scenarios are needed for the rest. Only they show that each address bit lands on the right line in both halves and both modes, that bank selection and byte lanes follow the captured request, and that the phase lengths come out right. They also show that a refresh slips between two accesses and that the counter wraps after 1024 refreshes.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ROW  = 3'd1,
      PH_RAS  = 3'd2,
      PH_COL  = 3'd3,
      PH_CAS  = 3'd4,
      PH_PRE  = 3'd5
   } phase_e;

   // captured access request; a[i] is word-address bit Ai
   typedef struct packed {
      logic [20:1] a;
      logic        up;     // upper lane wanted
      logic        lo;     // lower lane wanted
      logic        wr;     // write transfer
      logic        bank;   // legacy bank select
   } acc_t;

   localparam int MA_W = 10;

endpackage

// File: rtl/dmx_req_latch.sv
module dmx_req_latch
   import dmx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  acc_t req_acc,
   input  logic refresh_req,
   input  logic take_acc,
   input  logic take_rf,
   output logic acc_pend,
   output logic rf_pend,
   output acc_t cur_acc
);

   acc_t pend_acc;

   // waiting access: a new request overrides a same-cycle take
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_pend <= 1'b0;
         pend_acc <= '0;
      end else if (req) begin
         acc_pend <= 1'b1;
         pend_acc <= req_acc;
      end else if (take_acc) begin
         acc_pend <= 1'b0;
      end
   end

   // running access, copied when the sequencer takes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur_acc <= '0;
      else if (take_acc) cur_acc <= pend_acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rf_pend <= 1'b0;
      else if (refresh_req) rf_pend <= 1'b1;
      else if (take_rf)     rf_pend <= 1'b0;
   end

   AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (take_acc || take_rf) |-> (acc_pend || rf_pend)) else $error("take without pending request"); // R9

endmodule

// File: rtl/dmx_phase_ctl.sv
module dmx_phase_ctl
   import dmx_pkg::*;
#(
   parameter int T_ROW = 1,
   parameter int T_RAS = 2,
   parameter int T_COL = 1,
   parameter int T_CAS = 2,
   parameter int T_PRE = 1
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   acc_pend,
   input  logic   rf_pend,
   output phase_e phase,
   output logic   rfsh,
   output logic   take_acc,
   output logic   take_rf,
   output logic   rf_done
);

   localparam int TSUM = T_ROW + T_RAS + T_COL + T_CAS + T_PRE;
   localparam int TW   = $clog2(TSUM + 1);

   logic [TW-1:0] tmr;
   logic          last;
   phase_e        nxt;

   function automatic logic [TW-1:0] span_m1(input phase_e p);
      case (p)
         PH_ROW:  span_m1 = TW'(T_ROW - 1);
         PH_RAS:  span_m1 = TW'(T_RAS - 1);
         PH_COL:  span_m1 = TW'(T_COL - 1);
         PH_CAS:  span_m1 = TW'(T_CAS - 1);
         PH_PRE:  span_m1 = TW'(T_PRE - 1);
         default: span_m1 = '0;
      endcase
   endfunction

   assign last     = (tmr == '0);
   assign take_rf  = (phase == PH_IDLE) && rf_pend;
   assign take_acc = (phase == PH_IDLE) && !rf_pend && acc_pend;
   assign rf_done  = (phase == PH_RAS) && rfsh && last;

   always_comb begin
      nxt = phase;
      if (phase == PH_IDLE) begin
         if (rf_pend || acc_pend) nxt = PH_ROW;
      end else if (last) begin
         case (phase)
            PH_ROW:  nxt = PH_RAS;
            PH_RAS:  nxt = rfsh ? PH_PRE : PH_COL;
            PH_COL:  nxt = PH_CAS;
            PH_CAS:  nxt = PH_PRE;
            default: nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tmr   <= '0;
         rfsh  <= 1'b0;
      end else begin
         phase <= nxt;
         if (nxt != phase) tmr <= span_m1(nxt);
         else if (!last)   tmr <= tmr - 1'b1;
         if (take_rf)       rfsh <= 1'b1;
         else if (take_acc) rfsh <= 1'b0;
      end
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !last) |=> (phase == $past(phase))) else $error("phase left early"); // R8
   AST_RFSH_SKIPS_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RAS && rfsh && last) |=> (phase == PH_PRE)) else $error("refresh entered column"); // R6

endmodule

// File: rtl/dmx_rfsh_ctr.sv
module dmx_rfsh_ctr #(
   parameter int W = 10
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] row
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    row <= '0;
      else if (step) row <= row + 1'b1;
   end

endmodule

// File: rtl/dmx_addr_mux.sv
module dmx_addr_mux
   import dmx_pkg::*;
(
   input  logic [20:1]     a,
   input  logic [MA_W-1:0] rf_row,
   input  logic            drive,
   input  logic            col_sel,
   input  logic            rfsh,
   input  logic            wide,
   output logic [MA_W-1:0] ma
);

   logic [MA_W-1:0] row_ma, col_ma, raw;

   // low nine row lines take a contiguous run starting at A9
   for (genvar i = 0; i < 9; i++) begin : g_row
      assign row_ma[i] = a[i + 9];
   end
   assign row_ma[9] = a[19];

   // low eight column lines take a contiguous run starting at A1
   for (genvar i = 0; i < 8; i++) begin : g_col
      assign col_ma[i] = a[i + 1];
   end
   assign col_ma[8] = a[18];
   assign col_ma[9] = a[20];

   always_comb begin
      if (!drive)       raw = '0;
      else if (rfsh)    raw = rf_row;
      else if (col_sel) raw = col_ma;
      else              raw = row_ma;
   end

   assign ma = {wide & raw[9], raw[8:0]};

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
   import dmx_pkg::*;
#(
   parameter int T_ROW  = 1,
   parameter int T_RAS  = 2,
   parameter int T_COL  = 1,
   parameter int T_CAS  = 2,
   parameter int T_PRE  = 1,
   parameter int RFSH_W = 10
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic [20:1] cpu_addr,
   input  logic        hi_byte_n,
   input  logic        lo_byte_n,
   input  logic        rd_wr_n,
   input  logic        bank_hi,
   input  logic        mode_10b,
   input  logic        refresh_req,
   output logic [9:0]  dram_addr,
   output logic        ras_a_n,
   output logic        ras_b_n,
   output logic        cas_hi_n,
   output logic        cas_lo_n,
   output logic        we_n
);

   if (T_ROW < 1 || T_RAS < 1 || T_COL < 1 || T_CAS < 1 || T_PRE < 1) begin : g_bad_timing
      $error("every phase must last at least one clock");
   end
   if (RFSH_W < MA_W) begin : g_bad_rfsh
      $error("refresh counter narrower than the address bus");
   end

   acc_t   req_acc, cur_acc;
   logic   acc_pend, rf_pend, take_acc, take_rf, rf_done, rfsh;
   phase_e phase;
   logic [RFSH_W-1:0] rf_row;
   logic   ras_on, col_on, cas_on, ras_a, ras_b;

   assign req_acc = '{a: cpu_addr, up: !hi_byte_n, lo: !lo_byte_n,
                      wr: !rd_wr_n, bank: bank_hi};

   dmx_req_latch u_req (
      .clk(clk), .rst_n(rst_n), .req(req), .req_acc(req_acc),
      .refresh_req(refresh_req), .take_acc(take_acc), .take_rf(take_rf),
      .acc_pend(acc_pend), .rf_pend(rf_pend), .cur_acc(cur_acc));

   dmx_phase_ctl #(.T_ROW(T_ROW), .T_RAS(T_RAS), .T_COL(T_COL),
                   .T_CAS(T_CAS), .T_PRE(T_PRE)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc_pend(acc_pend), .rf_pend(rf_pend),
      .phase(phase), .rfsh(rfsh), .take_acc(take_acc), .take_rf(take_rf),
      .rf_done(rf_done));

   dmx_rfsh_ctr #(.W(RFSH_W)) u_rc (
      .clk(clk), .rst_n(rst_n), .step(rf_done), .row(rf_row));

   assign ras_on = (phase == PH_RAS) || (phase == PH_COL) || (phase == PH_CAS);
   assign col_on = (phase == PH_COL) || (phase == PH_CAS);
   assign cas_on = (phase == PH_CAS) && !rfsh;

   dmx_addr_mux u_mux (
      .a(cur_acc.a), .rf_row(rf_row[MA_W-1:0]),
      .drive(phase != PH_IDLE && phase != PH_PRE),
      .col_sel(col_on), .rfsh(rfsh), .wide(mode_10b), .ma(dram_addr));

   // refresh asserts both lines; wide mode steers accesses to line a
   assign ras_a = ras_on && (rfsh || mode_10b || !cur_acc.bank);
   assign ras_b = ras_on && (rfsh || (!mode_10b && cur_acc.bank));

   assign ras_a_n  = !ras_a;
   assign ras_b_n  = !ras_b;
   assign cas_hi_n = !(cas_on && cur_acc.up);
   assign cas_lo_n = !(cas_on && cur_acc.lo);
   assign we_n     = !(col_on && !rfsh && cur_acc.wr);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (ras_a_n && ras_b_n && cas_hi_n && cas_lo_n && we_n && dram_addr == '0))
      else $error("strobe active while idle"); // R10
   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_hi_n || !cas_lo_n) |-> (!ras_a_n || !ras_b_n)) else $error("column strobe without row strobe"); // R8
   AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh && phase != PH_IDLE) |-> (cas_hi_n && cas_lo_n && we_n)) else $error("column strobe in refresh"); // R6
   AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RAS && $past(phase) == PH_RAS) |-> $stable(dram_addr)) else $error("row moved under strobe"); // R8
   AST_WIDE_ONE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_10b && !rfsh) |-> ras_b_n) else $error("second row strobe in wide mode"); // R5
   AST_LEGACY_NO_MA9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_10b) |-> (dram_addr[9] == 1'b0)) else $error("tenth line driven in legacy mode"); // R4
   AST_RF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && rf_pend) |=> (rfsh && phase == PH_ROW)) else $error("refresh not served first"); // R9
   AST_RFSH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PRE && rfsh && $past(phase) == PH_RAS) |-> (rf_row == $past(rf_row) + 1'b1))
      else $error("refresh row did not advance"); // R7
   AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n) |-> (cur_acc.wr && !ras_a_n || cur_acc.wr && !ras_b_n)) else $error("write enable on read"); // R11

endmodule

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;

   localparam int T_ROW = 1, T_RAS = 2, T_COL = 1, T_CAS = 2, T_PRE = 1;
   localparam int RAS_ACC = T_RAS + T_COL + T_CAS;

   typedef struct packed {
      logic [20:0] a;
      logic hb_n, lb_n, rd, bank, wide;
      logic [9:0] row, col;
      logic r0, r1, cu, cl;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{21'h000000,1'b0,1'b0,1'b1,1'b0,1'b1,10'h000,10'h000,1'b1,1'b0,1'b1,1'b1},
      '{21'h1FFFFE,1'b0,1'b1,1'b0,1'b1,1'b1,10'h3FF,10'h3FF,1'b1,1'b0,1'b1,1'b0},
      '{21'h1FFFFE,1'b1,1'b0,1'b1,1'b1,1'b0,10'h1FF,10'h1FF,1'b0,1'b1,1'b0,1'b1},
      '{21'h080000,1'b0,1'b0,1'b1,1'b0,1'b1,10'h200,10'h000,1'b1,1'b0,1'b1,1'b1},
      '{21'h100000,1'b0,1'b0,1'b1,1'b0,1'b1,10'h000,10'h200,1'b1,1'b0,1'b1,1'b1},
      '{21'h040000,1'b0,1'b0,1'b1,1'b0,1'b1,10'h000,10'h100,1'b1,1'b0,1'b1,1'b1},
      '{21'h020000,1'b0,1'b0,1'b1,1'b0,1'b0,10'h100,10'h000,1'b1,1'b0,1'b1,1'b1},
      '{21'h000200,1'b0,1'b0,1'b1,1'b0,1'b1,10'h001,10'h000,1'b1,1'b0,1'b1,1'b1},
      '{21'h000002,1'b0,1'b0,1'b1,1'b1,1'b0,10'h000,10'h001,1'b0,1'b1,1'b1,1'b1},
      '{21'h0AAAAA,1'b0,1'b0,1'b0,1'b0,1'b1,10'h355,10'h055,1'b1,1'b0,1'b1,1'b1},
      '{21'h0AAAAA,1'b0,1'b0,1'b1,1'b0,1'b0,10'h155,10'h055,1'b1,1'b0,1'b1,1'b1},
      '{21'h100000,1'b1,1'b1,1'b1,1'b0,1'b0,10'h000,10'h000,1'b1,1'b0,1'b0,1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, hi_byte_n = 1'b1, lo_byte_n = 1'b1, rd_wr_n = 1'b1;
   logic bank_hi = 1'b0, mode_10b = 1'b1, refresh_req = 1'b0;
   logic [20:1] cpu_addr = '0;
   logic [9:0] dram_addr;
   logic ras_a_n, ras_b_n, cas_hi_n, cas_lo_n, we_n;

   always #10 clk = ~clk;

   dram_addr_mux #(.T_ROW(T_ROW), .T_RAS(T_RAS), .T_COL(T_COL), .T_CAS(T_CAS),
                   .T_PRE(T_PRE), .RFSH_W(10)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .cpu_addr(cpu_addr),
      .hi_byte_n(hi_byte_n), .lo_byte_n(lo_byte_n), .rd_wr_n(rd_wr_n),
      .bank_hi(bank_hi), .mode_10b(mode_10b), .refresh_req(refresh_req),
      .dram_addr(dram_addr), .ras_a_n(ras_a_n), .ras_b_n(ras_b_n),
      .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n), .we_n(we_n));

   int checks = 0, fails = 0;
   int rf_model = 0;

   // episode log: one entry per continuous stretch of any row strobe low
   int ep_n, bad_cas;
   bit ep_rf [8], ep_r0 [8], ep_r1 [8], ep_cu [8], ep_cl [8];
   logic [9:0] ep_row [8], ep_col [8];
   int ep_raslen [8], ep_caslen [8], ep_we [8];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic watch(input int n);
      bit in_ep = 1'b0;
      int k;
      ep_n = 0;
      bad_cas = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         if ((!cas_hi_n || !cas_lo_n) && ras_a_n && ras_b_n) bad_cas++;
         if (!ras_a_n || !ras_b_n) begin
            if (!in_ep) begin
               in_ep = 1'b1;
               if (ep_n < 8) begin
                  ep_rf[ep_n] = !ras_a_n && !ras_b_n;
                  ep_r0[ep_n] = !ras_a_n;
                  ep_r1[ep_n] = !ras_b_n;
                  ep_row[ep_n] = dram_addr;
                  ep_raslen[ep_n] = 0;
                  ep_caslen[ep_n] = 0;
                  ep_we[ep_n] = 0;
                  ep_cu[ep_n] = 1'b0;
                  ep_cl[ep_n] = 1'b0;
               end
               ep_n++;
            end
            k = ep_n - 1;
            if (k < 8) begin
               ep_raslen[k]++;
               ep_col[k] = dram_addr;
               if (!cas_hi_n || !cas_lo_n) ep_caslen[k]++;
               if (!cas_hi_n) ep_cu[k] = 1'b1;
               if (!cas_lo_n) ep_cl[k] = 1'b1;
               if (!we_n) ep_we[k]++;
            end
         end else begin
            in_ep = 1'b0;
            if (!we_n) ep_we[0] += 100;
         end
      end
   endtask

   task automatic put_req(input vec_t v);
      cpu_addr  = v.a[20:1];
      hi_byte_n = v.hb_n;
      lo_byte_n = v.lb_n;
      rd_wr_n   = v.rd;
      bank_hi   = v.bank;
      req       = 1'b1;
   endtask

   task automatic refresh_watched(input logic [9:0] exp_row, input string tag);
      refresh_req = 1'b1;
      @(negedge clk);
      refresh_req = 1'b0;
      watch(12);
      rf_model++;
      chk(ep_n == 1, {tag, " R6 one refresh episode"}, ep_n, 1);
      chk(ep_rf[0], {tag, " R6 both row strobes low"}, ep_rf[0], 1);
      chk(ep_row[0] == exp_row, {tag, " R7 refresh row"}, ep_row[0], exp_row);
      chk(ep_raslen[0] == T_RAS, {tag, " R6 refresh strobe length"}, ep_raslen[0], T_RAS);
      chk(ep_caslen[0] == 0 && ep_we[0] == 0, {tag, " R6 no column strobe"}, ep_caslen[0], 0);
   endtask

   task automatic refresh_silent();
      refresh_req = 1'b1;
      @(negedge clk);
      refresh_req = 1'b0;
      repeat (8) @(negedge clk);
      rf_model++;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // reset state, R10
      repeat (3) @(negedge clk);
      chk(ras_a_n && ras_b_n && cas_hi_n && cas_lo_n && we_n, "R10 strobes high in reset",
          {ras_a_n, ras_b_n, cas_hi_n, cas_lo_n, we_n}, 5'h1F);
      chk(dram_addr == 10'h000, "R10 bus zero in reset", dram_addr, 0);
      rst_n = 1'b1;
      watch(10);
      chk(ep_n == 0 && ep_we[0] == 0, "R10 no strobe without request", ep_n, 0);
      chk(dram_addr == 10'h000, "R10 bus zero while idle", dram_addr, 0);

      // table walk: R1 R2 R3 R4 R5 R8 R11
      for (int i = 0; i < NV; i++) begin
         mode_10b = VECS[i].wide;
         put_req(VECS[i]);
         @(negedge clk);
         req = 1'b0;
         cpu_addr = ~VECS[i].a[20:1];
         watch(16);
         chk(ep_n == 1, $sformatf("R8 vec%0d one episode", i), ep_n, 1);
         chk(ep_row[0] == VECS[i].row, $sformatf("R1/R4 vec%0d row", i), ep_row[0], VECS[i].row);
         chk(ep_col[0] == VECS[i].col, $sformatf("R2/R4 vec%0d column", i), ep_col[0], VECS[i].col);
         chk(ep_r0[0] == VECS[i].r0 && ep_r1[0] == VECS[i].r1, $sformatf("R4/R5 vec%0d row strobe line", i),
             {ep_r0[0], ep_r1[0]}, {VECS[i].r0, VECS[i].r1});
         chk(ep_cu[0] == VECS[i].cu && ep_cl[0] == VECS[i].cl, $sformatf("R3 vec%0d byte lanes", i),
             {ep_cu[0], ep_cl[0]}, {VECS[i].cu, VECS[i].cl});
         chk(ep_raslen[0] == RAS_ACC, $sformatf("R8 vec%0d row strobe length", i), ep_raslen[0], RAS_ACC);
         chk(ep_caslen[0] == ((VECS[i].cu | VECS[i].cl) ? T_CAS : 0), $sformatf("R8 vec%0d column strobe length", i),
             ep_caslen[0], (VECS[i].cu | VECS[i].cl) ? T_CAS : 0);
         chk(ep_we[0] == (VECS[i].rd ? 0 : T_COL + T_CAS), $sformatf("R11 vec%0d write enable", i),
             ep_we[0], VECS[i].rd ? 0 : T_COL + T_CAS);
         chk(bad_cas == 0, $sformatf("R8 vec%0d column strobe only under row strobe", i), bad_cas, 0);
      end

      // refresh rows from reset value, wide mode: R6 R7
      mode_10b = 1'b1;
      refresh_watched(10'h000, "rf0");
      refresh_watched(10'h001, "rf1");
      refresh_watched(10'h002, "rf2");

      // refresh slips between two accesses: R9
      fork
         watch(40);
         begin
            put_req(VECS[0]);
            @(negedge clk);
            req = 1'b0;
            repeat (3) @(negedge clk);
            put_req(VECS[7]);
            refresh_req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            refresh_req = 1'b0;
         end
      join
      chk(ep_n == 3, "R9 three episodes", ep_n, 3);
      chk(!ep_rf[0] && ep_row[0] == 10'h000, "R9 first access completes first", ep_rf[0], 0);
      chk(ep_rf[1] && ep_row[1] == 10'(rf_model), "R9 refresh served second", ep_row[1], rf_model);
      chk(!ep_rf[2] && ep_row[2] == 10'h001, "R9 later access runs last", ep_row[2], 1);
      rf_model++;

      // counter run-up, legacy masking of bit 9: R6 R7
      while (rf_model < 10'h2FF) refresh_silent();
      mode_10b = 1'b0;
      refresh_watched(10'h0FF, "rf_legacy R4");
      mode_10b = 1'b1;
      while (rf_model < 10'h3FF) refresh_silent();
      refresh_watched(10'h3FF, "rf_top");
      refresh_watched(10'h000, "rf_wrap R7");

      // both requests waiting at once: refresh first, R9
      fork
         watch(30);
         begin
            put_req(VECS[3]);
            refresh_req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            refresh_req = 1'b0;
         end
      join
      chk(ep_n == 2 && ep_rf[0] && ep_row[0] == 10'h001, "R9 simultaneous refresh wins", ep_row[0], 1);
      chk(!ep_rf[1] && ep_row[1] == 10'h200, "R9 access follows refresh", ep_row[1], 10'h200);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule